// File: doc/BRIEF.md
# Dual-Line GPIO Edge Interrupt Controller

This block watches up to 31 general-purpose input pins and records their transitions in two status registers. Each pin has its own polarity bit. The polarity bit picks which edge counts as the pin's "assert" event. The opposite edge is that pin's "deassert" event. Assert events go into the assert status register and deassert events go into the deassert status register. Each status register drives its own interrupt line. Software that wants both edges of a pin services both lines. Software that wants a single edge services only the assert line.

Software reaches the block through a 32-bit word-addressed register port with four words: the enable word, the polarity word, the assert status word and the deassert status word. In the two status words, bit 0 acts as a mode flag for writes. The flag decides whether the ones in bits 1 to 31 set or clear the matching status bits. This lets a handler acknowledge exactly the events it has consumed, and it lets test software inject events. Debouncing and the pin data and direction registers sit outside this block.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the enable, polarity and both status words are zero, both interrupt lines are low and `reg_rdata` is zero.
- R2: The enable word (address 0) and the polarity word (address 1) hold GPIO k at bit k. Writes are taken when `reg_wen` is high. Bits at and above NUM_PINS read as 0.
- R3: For an enabled pin with polarity 1, a rising edge sets bit k+1 of the assert status word (address 2), and a falling edge sets bit k+1 of the deassert status word (address 3).
- R4: For an enabled pin with polarity 0, a falling edge sets bit k+1 of the assert status word, and a rising edge sets bit k+1 of the deassert status word.
- R5: Edges on a pin whose enable bit is 0 leave both status words unchanged.
- R6: A status write with bit 0 = 0 clears every status bit whose bit is written as 1. Bits written as 0 keep their value.
- R7: A status write with bit 0 = 1 sets every status bit whose bit is written as 1. Bits written as 0 keep their value.
- R8: Bit 0 of either status word always reads as 0.
- R9: When an edge event and a clear of the same status bit land in the same cycle, the bit ends up set.
- R10: Each interrupt line is a register. It goes high one cycle after any of its status bits is set on an enabled pin, and goes low one cycle after no such bit remains. Status bits themselves are kept when the enable bit is cleared.
- R11: Pins pass through two synchronizer flops before edge detection, so a status bit is set on the third rising clock edge after the pin changes. `reg_rdata` shows the word selected by `reg_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_PINS | Asynchronous pin levels |
| reg_addr | input | 2 | Word select: 0 enable, 1 polarity, 2 assert status, 3 deassert status |
| reg_wen | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the word selected in the previous cycle |
| irq_assert | output | 1 | Interrupt line of the assert status word |
| irq_deassert | output | 1 | Interrupt line of the deassert status word |

## Verification
The bench targets an edge that arrives in the same cycle as a software clear of the same bit. A design that lets the clear win would lose that event without any trace. It also checks that a status write carrying only the mode flag changes nothing, and that the status bit for GPIO k sits at k+1. A design with an off-by-one here would acknowledge the wrong pin. Further checks cover an edge on a disabled pin, which must leave no trace, and polarity swapping, which must route each edge to the other register. They also cover an interrupt line that has to drop as soon as its pin is disabled, even though the status bit is still set. A long random phase mixes pin toggles with register writes and compares against a reference model on every clock.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_POLARITY = 2'd1,
    SEL_ASSERT   = 2'd2,
    SEL_DEASSERT = 2'd3
  } gei_sel_e;

  // Meaning of bit 0 in a status write
  typedef enum logic {
    WMODE_CLEAR = 1'b0,
    WMODE_SET   = 1'b1
  } gei_wmode_e;
endpackage

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
  parameter int unsigned N      = 31,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        last_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_in[k]};
        last_q <= sync_q[STAGES-1];
      end
    end

    assign rise[k] = sync_q[STAGES-1] & ~last_q;
    assign fall[k] = ~sync_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/gei_cfg_regs.sv
module gei_cfg_regs #(
  parameter int unsigned N = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_enable,
  input  logic         wr_polarity,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] enable_q,
  output logic [N-1:0] polarity_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q   <= '0;
      polarity_q <= '0;
    end else begin
      if (wr_enable)   enable_q   <= wr_bits;
      if (wr_polarity) polarity_q <= wr_bits;
    end
  end
endmodule

// File: rtl/gei_status_reg.sv
module gei_status_reg
  import gei_pkg::*;
#(
  parameter int unsigned N = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      evt,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [N-1:0]      status_q
);
  gei_wmode_e   mode;
  logic [N-1:0] touch;
  logic [N-1:0] status_d;

  assign mode  = gei_wmode_e'(wr_data[0]);
  assign touch = wr_en ? wr_data[N:1] : '0;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_comb begin
      status_d[k] = status_q[k];
      if (touch[k]) status_d[k] = (mode == WMODE_SET);
      // a fresh event overrides a clear in the same cycle
      if (evt[k]) status_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int unsigned NUM_PINS = 31,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] gpio_in,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wen,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_assert,
  output logic                irq_deassert
);
  gei_sel_e            sel;
  logic [NUM_PINS-1:0] rise, fall;
  logic [NUM_PINS-1:0] en_q, pol_q;
  logic [NUM_PINS-1:0] evt_a, evt_d;
  logic [NUM_PINS-1:0] stat_a, stat_d;
  logic [WORD_W-1:0]   rd_next;

  assign sel = gei_sel_e'(reg_addr);

  gei_edge_detect #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_in(gpio_in), .rise(rise), .fall(fall)
  );

  gei_cfg_regs #(.N(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_enable(reg_wen && sel == SEL_ENABLE),
    .wr_polarity(reg_wen && sel == SEL_POLARITY),
    .wr_bits(reg_wdata[NUM_PINS-1:0]),
    .enable_q(en_q), .polarity_q(pol_q)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_steer
    assign evt_a[k] = en_q[k] & (pol_q[k] ? rise[k] : fall[k]);
    assign evt_d[k] = en_q[k] & (pol_q[k] ? fall[k] : rise[k]);
  end

  gei_status_reg #(.N(NUM_PINS)) u_stat_a (
    .clk(clk), .rst(rst), .evt(evt_a),
    .wr_en(reg_wen && sel == SEL_ASSERT), .wr_data(reg_wdata),
    .status_q(stat_a)
  );

  gei_status_reg #(.N(NUM_PINS)) u_stat_d (
    .clk(clk), .rst(rst), .evt(evt_d),
    .wr_en(reg_wen && sel == SEL_DEASSERT), .wr_data(reg_wdata),
    .status_q(stat_d)
  );

  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_ENABLE:   rd_next[NUM_PINS-1:0] = en_q;
      SEL_POLARITY: rd_next[NUM_PINS-1:0] = pol_q;
      SEL_ASSERT:   rd_next[NUM_PINS:0]   = {stat_a, 1'b0};
      SEL_DEASSERT: rd_next[NUM_PINS:0]   = {stat_d, 1'b0};
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      irq_assert   <= 1'b0;
      irq_deassert <= 1'b0;
    end else begin
      reg_rdata    <= rd_next;
      irq_assert   <= |(stat_a & en_q);
      irq_deassert <= |(stat_d & en_q);
    end
  end
endmodule

// File: rtl/gei_checker.sv
module gei_checker #(
  parameter int unsigned N = 31
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   reg_addr,
  input logic         reg_wen,
  input logic [31:0]  reg_rdata,
  input logic         irq_assert,
  input logic         irq_deassert,
  input logic [N-1:0] en,
  input logic [N-1:0] evt_a,
  input logic [N-1:0] evt_d,
  input logic [N-1:0] stat_a,
  input logic [N-1:0] stat_d
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_assert && !irq_deassert && reg_rdata == '0));

  assert_event_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_a & evt_d) == '0);

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wen && reg_addr == 2'd2) |=> ((stat_a & ~$past(stat_a) & ~$past(en)) == '0));

  assert_bit0_low_R8: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr[1]) |-> (reg_rdata[0] == 1'b0));

  assert_edge_wins_a_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_a != '0) |=> ((stat_a & $past(evt_a)) == $past(evt_a)));

  assert_edge_wins_d_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_d != '0) |=> ((stat_d & $past(evt_d)) == $past(evt_d)));

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
    ((stat_a & en) != '0) |=> irq_assert);

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (rst)
    ((stat_d & en) == '0) |=> !irq_deassert);
endmodule

bind gpio_edge_irq gei_checker #(.N(NUM_PINS)) u_gei_checker (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
  .reg_rdata(reg_rdata), .irq_assert(irq_assert), .irq_deassert(irq_deassert),
  .en(en_q), .evt_a(evt_a), .evt_d(evt_d), .stat_a(stat_a), .stat_d(stat_d)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int N = 31;
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] gpio_in = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_assert, irq_deassert;

  always #10 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(N)) i_gpio_edge_irq (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_assert(irq_assert), .irq_deassert(irq_deassert)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [N-1:0] m_en = '0, m_pol = '0, m_sa = '0, m_sd = '0;
  logic [31:0]  m_rd = '0;
  logic         m_ia = 1'b0, m_id = 1'b0;
  logic [N-1:0] pins = '0;

  function automatic logic [31:0] model_word(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_en};
      2'd1: return {1'b0, m_pol};
      2'd2: return {m_sa, 1'b0};
      default: return {m_sd, 1'b0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d);
    logic [N-1:0] rise, fall, ea, ed, nsa, nsd;
    gpio_in = pins; reg_wen = w; reg_addr = a; reg_wdata = d;
    rise = m_s2 & ~m_prev;
    fall = ~m_s2 & m_prev;
    ea = m_en & ((m_pol & rise) | (~m_pol & fall));
    ed = m_en & ((m_pol & fall) | (~m_pol & rise));
    nsa = m_sa; nsd = m_sd;
    if (w && a == 2'd2) nsa = d[0] ? (nsa | d[N:1]) : (nsa & ~d[N:1]);
    if (w && a == 2'd3) nsd = d[0] ? (nsd | d[N:1]) : (nsd & ~d[N:1]);
    nsa |= ea; nsd |= ed;
    @(posedge clk);
    m_rd = model_word(a);
    m_ia = |(m_sa & m_en);
    m_id = |(m_sd & m_en);
    m_sa = nsa; m_sd = nsd;
    if (w && a == 2'd0) m_en  = d[N-1:0];
    if (w && a == 2'd1) m_pol = d[N-1:0];
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    @(negedge clk);
    // per-cycle comparison: R10 interrupt lines, R11 read path
    check("R10 irq lines vs model", {30'd0, irq_assert, irq_deassert}, {30'd0, m_ia, m_id});
    check("R11 rdata vs model", reg_rdata, m_rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0);
  endtask

  task automatic expect_word(input string tag, input logic [1:0] a, input logic [31:0] exp);
    cyc(1'b0, a, 32'd0);
    check(tag, reg_rdata, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset rdata", reg_rdata, 32'd0);
    check("R1 reset irqs", {30'd0, irq_assert, irq_deassert}, 32'd0);
    expect_word("R1 enable after reset", 2'd0, 32'd0);
    expect_word("R1 assert status after reset", 2'd2, 32'd0);

    // R2 config words; bit 31 has no pin
    cyc(1'b1, 2'd0, 32'h8000_00FF);
    cyc(1'b1, 2'd1, 32'h0000_000F);
    expect_word("R2 enable readback", 2'd0, 32'h0000_00FF);
    expect_word("R2 polarity readback", 2'd1, 32'h0000_000F);

    // R3/R4: pin0 (pol 1) and pin4 (pol 0) rise
    pins[0] = 1'b1; pins[4] = 1'b1;
    idle(4);
    expect_word("R3 rising pin0 pol1 -> assert bit1", 2'd2, 32'h0000_0002);
    expect_word("R4 rising pin4 pol0 -> deassert bit5", 2'd3, 32'h0000_0020);
    check("R10 both lines high", {30'd0, irq_assert, irq_deassert}, 32'd3);

    // R5: pin20 disabled
    pins[20] = 1'b1;
    idle(4);
    expect_word("R5 disabled pin assert", 2'd2, 32'h0000_0002);
    expect_word("R5 disabled pin deassert", 2'd3, 32'h0000_0020);

    // opposite edges
    pins[0] = 1'b0; pins[4] = 1'b0;
    idle(4);
    expect_word("R3 falling pin0 -> deassert / R4 falling pin4 -> assert", 2'd2, 32'h0000_0022);
    expect_word("R3 R4 deassert word", 2'd3, 32'h0000_0022);

    // R6 clear
    cyc(1'b1, 2'd2, 32'h0000_0002);
    expect_word("R6 clear bit1 keeps bit5", 2'd2, 32'h0000_0020);
    // R7 set
    cyc(1'b1, 2'd3, 32'h0000_0101);
    expect_word("R7 set bit8", 2'd3, 32'h0000_0122);
    // R8 flag alone changes nothing and reads 0
    cyc(1'b1, 2'd2, 32'h0000_0001);
    expect_word("R8 bit0 reads 0, word unchanged", 2'd2, 32'h0000_0020);

    // R9: edge of pin1 reaches status on same edge as clear of bit2
    pins[1] = 1'b1;
    cyc(1'b0, 2'd0, 32'd0);
    cyc(1'b0, 2'd0, 32'd0);
    cyc(1'b1, 2'd2, 32'h0000_0004);
    expect_word("R9 edge beats clear", 2'd2, 32'h0000_0024);

    // R11 latency: pin2 rises, assert bit3 visible on rdata after 4 cycles
    pins[2] = 1'b1;
    cyc(1'b0, 2'd2, 32'd0);
    cyc(1'b0, 2'd2, 32'd0);
    cyc(1'b0, 2'd2, 32'd0);
    check("R11 bit3 not yet visible", {31'd0, reg_rdata[3]}, 32'd0);
    cyc(1'b0, 2'd2, 32'd0);
    check("R11 bit3 visible", {31'd0, reg_rdata[3]}, 32'd1);

    // R10: disabling drops the line, status kept
    cyc(1'b1, 2'd0, 32'd0);
    check("R10 line still high one cycle", {31'd0, irq_assert}, 32'd1);
    cyc(1'b0, 2'd0, 32'd0);
    check("R10 line low after disable", {31'd0, irq_assert}, 32'd0);
    expect_word("R10 status kept while disabled", 2'd2, 32'h0000_002C);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) pins = N'($urandom);
      else if (r[5:4] == 2'd0) pins[r[12:8] % N] = ~pins[r[12:8] % N];
      if (r[20:18] == 3'd0) cyc(1'b1, r[25:24], $urandom);
      else cyc(1'b0, r[25:24], 32'd0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule